// File: doc/BRIEF.md
# Parallel Time-Multiplexed Correlator

This block cross-correlates a fast sample stream against a stored reference template. The stream arrives as `LANES` samples per clock, with lane 0 the earliest. Each clock the block forms a grid of products between a sliding window of samples and one slice of `LANES` template coefficients. This gives `NLAGS` partial correlation values at once, and each is added into its own accumulator. After `TLEN/LANES` clocks the whole template has been covered. All lag results are then presented together with a one-cycle valid strobe, and the next window begins on the very next clock.

Samples and coefficients use a 4-bit sign-magnitude code. Bit 3 is the sign and bits 2:0 are the magnitude. Software fills the template one coefficient per clock through a write port while the correlator is stopped. A small state machine has two states. In ST_IDLE the correlator is stopped and captures nothing into the accumulators. ST_ACCUM steps through the template slices. Its transitions are: *capture* (ST_IDLE to ST_ACCUM when `run_en` is high, which registers the first sample group), *wrap* (staying in ST_ACCUM when the last slice is reached, which returns the slice index to 0), and *abort* (ST_ACCUM to ST_IDLE when `run_en` is low, which drops the partial window).

Top module: `parallel_corr`

## Requirements
- R1: A code is read as sign bit 3 and magnitude bits 2:0. Code 4'b1000 (negative zero) counts as the value 0, in both samples and coefficients.
- R2: Lane i of `samp_i` occupies bits [4i+3:4i], and lane 0 is the earliest sample of the group. Number the sample groups from the capture edge, starting at 0. Window w starts at sample index b = w*TLEN. Lag j of that window equals the sum over n = 0..TLEN-1 of x[b+j+n]*h[n]. Lag j is placed at bits [14j+13:14j] of `lag_sum_o`.
- R3: A write with `tpl_we` high stores `tpl_coef` as coefficient h[`tpl_addr`]. Every window that starts after the write uses the new value.
- R4: Each lag is a 14-bit two's-complement value and holds the exact result, including the extremes +7840 and -7840.
- R5: While `run_en` stays high, the first valid pulse follows the edge that captures group TLEN/LANES. Later pulses come every TLEN/LANES clocks, with no gap between windows, and each pulse lasts one cycle.
- R6: When `run_en` is low at an edge, no valid pulse follows it and the partial window is discarded. The next high `run_en` starts a new window alignment at that group.
- R7: `lag_sum_o` holds its value in every cycle without a valid pulse.
- R8: After reset, `sum_valid_o` is low, all lag outputs are zero and the template is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_en | input | 1 | Correlator enable; low aborts the current window |
| samp_i | input | LANES*4 | One group of sign-magnitude samples, lane 0 earliest |
| tpl_we | input | 1 | Template write strobe |
| tpl_addr | input | $clog2(TLEN) | Template coefficient index |
| tpl_coef | input | 4 | Sign-magnitude coefficient to store |
| lag_sum_o | output | NLAGS*14 | Correlation results, lag j at bits [14j+13:14j] |
| sum_valid_o | output | 1 | One-cycle strobe marking fresh results |

## Verification
The first pattern is an impulse template against a ramp of sample codes. With it each lag reproduces one sample, which exposes swapped lanes, an off-by-one in the window and a misplaced lag field. Two constant patterns follow: all maximum-positive codes, then all maximum-negative codes. They drive the sums to both extremes, so a narrow accumulator or a wrong sign rule shows up. Random templates and samples are then run, with many negative-zero codes mixed in. These separate the sign-magnitude handling from a two's-complement reading and confirm that template reloads are used. A run that is stopped in the middle of a window and restarted shows whether stale partial sums leak into the next result.

// File: rtl/corr_pkg.sv
package corr_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_ACCUM
    } corr_state_e;

    // Sign-magnitude multiply: magnitude product, sign from XOR of signs.
    // A zero magnitude yields zero whatever the sign bits are.
    function automatic logic signed [7:0] sm_mul(input logic [3:0] a, input logic [3:0] b);
        logic [5:0]        mag;
        logic signed [7:0] r;
        mag = 6'({3'b000, a[2:0]} * {3'b000, b[2:0]});
        r   = $signed({2'b00, mag});
        return (a[3] ^ b[3]) ? -r : r;
    endfunction

endpackage

// File: rtl/corr_tpl_store.sv
module corr_tpl_store #(
    parameter int TLEN  = 160,
    parameter int LANES = 8,
    parameter int AW    = $clog2(TLEN),
    parameter int SLW   = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [AW-1:0]        addr,
    input  logic [3:0]           coef,
    input  logic [SLW-1:0]       slice_i,
    output logic [LANES*4-1:0]   slice_coefs_o
);
    logic [3:0] mem [TLEN];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < TLEN; n++) mem[n] <= '0;
        end else if (we && ({1'b0, addr} < (AW+1)'(TLEN))) begin
            mem[addr] <= coef;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_rd
        logic [AW-1:0] idx;
        assign idx = AW'(int'(slice_i) * LANES + i);
        assign slice_coefs_o[4*i +: 4] = mem[idx];
    end
endmodule

// File: rtl/corr_mac_array.sv
module corr_mac_array #(
    parameter int LANES = 8,
    parameter int NLAGS = 8,
    parameter int SUMW  = 14
) (
    input  logic [LANES*4-1:0]       prev_i,
    input  logic [LANES*4-1:0]       cur_i,
    input  logic [LANES*4-1:0]       coef_i,
    output logic [NLAGS*SUMW-1:0]    part_o
);
    // Two consecutive groups form the window; lag j, tap i reads sample i+j.
    logic [2*LANES*4-1:0] win;
    assign win = {cur_i, prev_i};

    for (genvar j = 0; j < NLAGS; j++) begin : g_lag
        logic signed [SUMW-1:0] s;
        always_comb begin
            s = '0;
            for (int i = 0; i < LANES; i++) begin
                s = s + SUMW'(corr_pkg::sm_mul(win[4*(i+j) +: 4], coef_i[4*i +: 4]));
            end
        end
        assign part_o[j*SUMW +: SUMW] = s;
    end
endmodule

// File: rtl/corr_seq_ctrl.sv
module corr_seq_ctrl #(
    parameter int NSLICE = 20,
    parameter int SLW    = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           run_en,
    output logic [SLW-1:0] slice_o,
    output logic           accum_o,
    output logic           first_o,
    output logic           last_o
);
    import corr_pkg::*;

    corr_state_e    state_q, state_d;
    logic [SLW-1:0] slice_q, slice_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slice_q <= '0;
        end else begin
            state_q <= state_d;
            slice_q <= slice_d;
        end
    end

    always_comb begin
        state_d = state_q;
        slice_d = slice_q;
        unique case (state_q)
            ST_IDLE: begin
                slice_d = '0;
                if (run_en) state_d = ST_ACCUM;            // capture
            end
            ST_ACCUM: begin
                if (!run_en) begin
                    state_d = ST_IDLE;                     // abort
                    slice_d = '0;
                end else if (slice_q == SLW'(NSLICE-1)) begin
                    slice_d = '0;                          // wrap
                end else begin
                    slice_d = slice_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        slice_o = slice_q;
        accum_o = (state_q == ST_ACCUM) && run_en;
        first_o = (slice_q == '0);
        last_o  = (slice_q == SLW'(NSLICE-1));
    end
endmodule

// File: rtl/parallel_corr.sv
module parallel_corr #(
    parameter int LANES = 8,
    parameter int NLAGS = 8,
    parameter int TLEN  = 160
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          run_en,
    input  logic [LANES*4-1:0]            samp_i,
    input  logic                          tpl_we,
    input  logic [$clog2(TLEN)-1:0]       tpl_addr,
    input  logic [3:0]                    tpl_coef,
    output logic [NLAGS*($clog2(TLEN*49+1)+1)-1:0] lag_sum_o,
    output logic                          sum_valid_o
);
    localparam int NSLICE = TLEN / LANES;
    localparam int SLW    = (NSLICE > 1) ? $clog2(NSLICE) : 1;
    localparam int ACC_W  = $clog2(TLEN*49+1) + 1;
    localparam int AW     = $clog2(TLEN);

    logic [LANES*4-1:0]     prev_q;
    logic [LANES*4-1:0]     coefs;
    logic [NLAGS*ACC_W-1:0] part;
    logic [SLW-1:0]         slice;
    logic                   accum, first, last;
    logic                   valid_q;

    corr_seq_ctrl #(.NSLICE(NSLICE), .SLW(SLW)) i_ctrl (
        .clk(clk), .rst(rst), .run_en(run_en),
        .slice_o(slice), .accum_o(accum), .first_o(first), .last_o(last)
    );

    corr_tpl_store #(.TLEN(TLEN), .LANES(LANES), .AW(AW), .SLW(SLW)) i_tpl (
        .clk(clk), .rst(rst), .we(tpl_we), .addr(tpl_addr), .coef(tpl_coef),
        .slice_i(slice), .slice_coefs_o(coefs)
    );

    corr_mac_array #(.LANES(LANES), .NLAGS(NLAGS), .SUMW(ACC_W)) i_mac (
        .prev_i(prev_q), .cur_i(samp_i), .coef_i(coefs), .part_o(part)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            prev_q  <= samp_i;
            valid_q <= accum && last;
        end
    end

    for (genvar j = 0; j < NLAGS; j++) begin : g_acc
        logic signed [ACC_W-1:0] acc_q, out_q, nxt;
        assign nxt = (first ? '0 : acc_q) + $signed(part[j*ACC_W +: ACC_W]);
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q <= '0;
                out_q <= '0;
            end else if (accum) begin
                acc_q <= nxt;
                if (last) out_q <= nxt;
            end
        end
        assign lag_sum_o[j*ACC_W +: ACC_W] = out_q;
    end

    assign sum_valid_o = valid_q;
endmodule

// File: rtl/parallel_corr_chk.sv
module parallel_corr_chk #(
    parameter int LANES = 8,
    parameter int NLAGS = 8,
    parameter int TLEN  = 160
) (
    input logic                                     clk,
    input logic                                     rst,
    input logic                                     run_en,
    input logic [NLAGS*($clog2(TLEN*49+1)+1)-1:0]   lag_sum_o,
    input logic                                     sum_valid_o
);
    localparam int NSLICE = TLEN / LANES;
    localparam int ACC_W  = $clog2(TLEN*49+1) + 1;
    localparam int LIM    = TLEN * 49;
    localparam int CW     = $clog2(NSLICE + 2) + 1;

    // Edges since the last window boundary; all-ones while stopped.
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk) begin
        if (rst || !run_en) cnt_q <= '1;
        else if (sum_valid_o) cnt_q <= CW'(1);
        else cnt_q <= cnt_q + 1'b1;
    end

    a_r5_window_period: assert property (@(posedge clk) disable iff (rst)
        sum_valid_o |-> (cnt_q == CW'(NSLICE)));

    a_r6_stop_no_valid: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !sum_valid_o);

    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sum_valid_o || $stable(lag_sum_o)));

    for (genvar j = 0; j < NLAGS; j++) begin : g_rng
        a_r4_in_range: assert property (@(posedge clk) disable iff (rst)
            sum_valid_o |-> ((int'($signed(lag_sum_o[j*ACC_W +: ACC_W])) <= LIM) &&
                             (int'($signed(lag_sum_o[j*ACC_W +: ACC_W])) >= -LIM)));
    end
endmodule

bind parallel_corr parallel_corr_chk #(.LANES(LANES), .NLAGS(NLAGS), .TLEN(TLEN)) i_chk (
    .clk(clk), .rst(rst), .run_en(run_en), .lag_sum_o(lag_sum_o), .sum_valid_o(sum_valid_o)
);

// File: tb/test_parallel_corr.sv
`timescale 1ns/100ps
module test_parallel_corr;
    localparam int LANES  = 8;
    localparam int NLAGS  = 8;
    localparam int TLEN   = 160;
    localparam int NSLICE = TLEN / LANES;
    localparam int ACC_W  = 14;
    localparam int AW     = $clog2(TLEN);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic [LANES*4-1:0] samp = '0;
    logic tpl_we = 1'b0;
    logic [AW-1:0] tpl_addr = '0;
    logic [3:0] tpl_coef = '0;
    logic [NLAGS*ACC_W-1:0] lag_sum;
    logic sum_valid;

    always #2.5 clk = ~clk;

    parallel_corr #(.LANES(LANES), .NLAGS(NLAGS), .TLEN(TLEN)) i_parallel_corr (
        .clk(clk), .rst(rst), .run_en(run_en), .samp_i(samp),
        .tpl_we(tpl_we), .tpl_addr(tpl_addr), .tpl_coef(tpl_coef),
        .lag_sum_o(lag_sum), .sum_valid_o(sum_valid)
    );

    int n_chk = 0, n_fail = 0;
    int tplm[TLEN];
    int hist[$];
    bit running = 0;
    int ngrp = 0;
    int exp_sum[NLAGS];
    bit exp_valid = 0;
    string sum_tag = "R2";

    function automatic int smval(input logic [3:0] c);
        return c[3] ? -int'(c[2:0]) : int'(c[2:0]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic compare();
        chk(sum_valid == exp_valid, run_en ? "R5" : "R6", int'(sum_valid), int'(exp_valid));
        for (int j = 0; j < NLAGS; j++) begin
            int a;
            a = int'($signed(lag_sum[j*ACC_W +: ACC_W]));
            chk(a == exp_sum[j], exp_valid ? sum_tag : "R7", a, exp_sum[j]);
        end
    endtask

    // Called at a negative edge: drive, step one clock, update model, compare.
    task automatic cyc(input bit en, input logic [LANES*4-1:0] grp,
                       input bit we, input int addr, input logic [3:0] coef);
        run_en = en; samp = grp; tpl_we = we; tpl_addr = AW'(addr); tpl_coef = coef;
        @(posedge clk);
        if (we && addr < TLEN) tplm[addr] = smval(coef);
        exp_valid = 0;
        if (en) begin
            if (!running) begin
                running = 1; hist.delete(); ngrp = 0;
            end
            for (int i = 0; i < LANES; i++) hist.push_back(smval(grp[4*i +: 4]));
            ngrp++;
            if (ngrp > 1 && (ngrp - 1) % NSLICE == 0) begin
                int base;
                base = ((ngrp - 1) / NSLICE - 1) * TLEN;
                for (int j = 0; j < NLAGS; j++) begin
                    int s;
                    s = 0;
                    for (int n = 0; n < TLEN; n++) s += hist[base + j + n] * tplm[n];
                    exp_sum[j] = s;
                end
                exp_valid = 1;
            end
        end else begin
            running = 0;
        end
        #1;
        compare();
        @(negedge clk);
    endtask

    task automatic load_tpl(input int mode);
        for (int n = 0; n < TLEN; n++) begin
            logic [3:0] c;
            case (mode)
                0: c = (n == 0) ? 4'b0001 : ((n % 3 == 0) ? 4'b1000 : 4'b0000);
                1: c = 4'b0111;
                default: c = ($urandom % 4 == 0) ? 4'b1000 : 4'($urandom);
            endcase
            cyc(0, '0, 1, n, c);
        end
    endtask

    function automatic logic [LANES*4-1:0] fill(input logic [3:0] c);
        logic [LANES*4-1:0] g;
        for (int i = 0; i < LANES; i++) g[4*i +: 4] = c;
        return g;
    endfunction

    function automatic logic [LANES*4-1:0] rnd_grp(input bit many_negzero);
        logic [LANES*4-1:0] g;
        g = $urandom;
        if (many_negzero)
            for (int i = 0; i < LANES; i++) if ($urandom % 3 == 0) g[4*i +: 4] = 4'b1000;
        return g;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int n = 0; n < TLEN; n++) tplm[n] = 0;
        for (int j = 0; j < NLAGS; j++) exp_sum[j] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        #0;
        chk(sum_valid == 1'b0, "R8", int'(sum_valid), 0);
        chk(lag_sum == '0, "R8", int'(lag_sum != '0), 0);
        // R8: stopped run with zero template gives zero sums
        sum_tag = "R8";
        for (int g = 0; g < NSLICE + 1; g++) cyc(1, rnd_grp(0), 0, 0, '0);
        cyc(0, '0, 0, 0, '0);

        // R2: impulse template (with negative-zero fill) against a code ramp
        load_tpl(0);
        sum_tag = "R2";
        for (int g = 0; g < 3*NSLICE + 1; g++) begin
            logic [LANES*4-1:0] grp;
            for (int i = 0; i < LANES; i++) grp[4*i +: 4] = 4'((g*LANES + i) % 16);
            cyc(1, grp, 0, 0, '0);
        end
        cyc(0, '0, 0, 0, '0);

        // R4: positive and negative extremes
        load_tpl(1);
        sum_tag = "R4";
        for (int g = 0; g < NSLICE + 1; g++) cyc(1, fill(4'b0111), 0, 0, '0);
        cyc(0, '0, 0, 0, '0);
        for (int g = 0; g < NSLICE + 1; g++) cyc(1, fill(4'b1111), 0, 0, '0);
        cyc(0, '0, 0, 0, '0);

        // R3: reloaded random template is used by following windows
        load_tpl(2);
        sum_tag = "R3";
        for (int g = 0; g < 2*NSLICE + 1; g++) cyc(1, rnd_grp(0), 0, 0, '0);
        cyc(0, '0, 0, 0, '0);

        // R1: frequent negative-zero sample codes
        sum_tag = "R1";
        for (int g = 0; g < 3*NSLICE + 1; g++) cyc(1, rnd_grp(1), 0, 0, '0);

        // R6: stop mid-window, then restart with a fresh alignment
        sum_tag = "R6";
        for (int g = 0; g < 7; g++) cyc(1, rnd_grp(0), 0, 0, '0);
        for (int g = 0; g < 3; g++) cyc(0, rnd_grp(0), 0, 0, '0);
        for (int g = 0; g < 2*NSLICE + 1; g++) cyc(1, rnd_grp(1), 0, 0, '0);
        // R7: outputs hold while idle
        for (int g = 0; g < 5; g++) cyc(0, rnd_grp(0), 0, 0, '0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule